// File: doc/BRIEF.md
# Threshold Motion Interrupt Generator

This block watches a stream of three-axis signed acceleration samples and raises an interrupt when the motion matches a programmed pattern. It takes the magnitude of each axis and compares it with one unsigned threshold. The comparison gives two events per axis: a high event and a low event. Six enable bits choose which events take part. The enabled events are then merged into one condition, either as an OR (any event) or as an AND (every enabled event).

The merged condition must hold for a programmable number of consecutive samples before it counts as an interrupt. When it counts, a source register records which enabled events were true and sets an interrupt-active flag. In latched mode the register keeps its content until it is read. In non-latched mode it follows each new sample.

The interrupt pin is driven from the interrupt-active flag. The polarity can be set to active-high or active-low. The drive can be push-pull, or open-drain, where the pin is driven only while active. The block is used behind a sample-rate strobe, so duration counts are in sample periods.

Top module: `motion_irq_gen`

## Requirements
- R1: After synchronous reset, `src_q` is 0, the duration count is cleared, and the pin is inactive: `irq_o` equals `pin_act_low`, and `irq_oe` is 1 in push-pull mode and 0 in open-drain mode.
- R2: For each axis, magnitude is the absolute value of the two's-complement sample (the most negative value gives its full positive magnitude). The high event is true when magnitude > `thr`, the low event when magnitude < `thr`, and at equality neither is true. The event and enable bit positions are bit0 X low, bit1 X high, bit2 Y low, bit3 Y high, bit4 Z low, bit5 Z high.
- R3: With `comb_and` = 0 the condition is true when any enabled event is true.
- R4: With `comb_and` = 1 the condition is true when every enabled event is true. If no event is enabled, the condition is false.
- R5: An interrupt fires on a strobed sample whose condition is true when at least `dur` immediately preceding strobed samples also had a true condition. With `dur` = 0 it fires on the first true sample.
- R6: A strobed sample with a false condition restarts the consecutive count, so a later interrupt again needs `dur` preceding true samples.
- R7: `src_q` bit 6 is the interrupt-active flag and bits 5..0 hold the fired events masked by the enables, in the R2 positions. It updates on the clock edge that takes the strobe.
- R8: With `latch_en` = 0, each strobed sample rewrites `src_q`: the new events when an interrupt fires, 0 otherwise. `src_rd` has no effect.
- R9: With `latch_en` = 1, `src_q` holds its bits and an interrupt ORs new bits in. `src_rd` clears it on the next edge, unless an interrupt fires in the same cycle, in which case the new bits are loaded.
- R10: `irq_o` is the interrupt-active flag when `pin_act_low` = 0 and its inverse when `pin_act_low` = 1.
- R11: With `pin_open_drain` = 1, `irq_oe` is 1 only while the flag is set. With `pin_open_drain` = 0, `irq_oe` is always 1.
- R12: Sample inputs without `smp_valid` are ignored: `src_q` and the count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe, one cycle per new sample |
| smp_x | input | DATA_W | Signed X sample |
| smp_y | input | DATA_W | Signed Y sample |
| smp_z | input | DATA_W | Signed Z sample |
| thr | input | THR_W | Unsigned magnitude threshold |
| dur | input | DUR_W | Required preceding true samples |
| evt_en | input | 6 | Event enables (R2 positions) |
| comb_and | input | 1 | 0: OR combination, 1: AND combination |
| latch_en | input | 1 | Hold source bits until read |
| src_rd | input | 1 | Read strobe for the source register |
| pin_act_low | input | 1 | Pin polarity, 1 = active-low |
| pin_open_drain | input | 1 | Pin drive, 1 = open-drain |
| src_q | output | 7 | Interrupt-active flag and event bits |
| irq_o | output | 1 | Pin output level |
| irq_oe | output | 1 | Pin output enable |

## Verification
A wrong comparison or combination shows up in `src_q` on the edge right after the strobed sample. It appears as a wrong event bit or a missing flag, and the pin follows in the same cycle. A stuck or mis-cleared duration counter stays hidden until a run of samples reaches the programmed length. The interrupt then arrives one or more samples early or late, so runs are checked one sample at a time around the threshold count. A fault in the latch or read-clear logic shows only in the sample or read after the fire. For that reason, held values are checked again after idle cycles and after reads.

// File: rtl/mot_pkg.sv
package mot_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_THR_W  = 7;
    localparam int DEF_DUR_W  = 7;
    localparam int NUM_AXES   = 3;
    localparam int EVT_W      = 2 * NUM_AXES;
    localparam int SRC_W      = EVT_W + 1;

    typedef enum logic {
        COMB_OR  = 1'b0,
        COMB_AND = 1'b1
    } comb_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } axis_evt_t;

    typedef struct packed {
        logic act_low;
        logic open_drain;
    } pin_cfg_t;

endpackage

// File: rtl/axis_cmp.sv
module axis_cmp
    import mot_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int THR_W  = DEF_THR_W
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [THR_W-1:0]  thr,
    output axis_evt_t                evt
);
    localparam int CMP_W = (DATA_W > THR_W) ? DATA_W : THR_W;

    logic [DATA_W-1:0] mag;
    logic [CMP_W-1:0]  mag_x;
    logic [CMP_W-1:0]  thr_x;

    always_comb begin
        mag   = sample[DATA_W-1] ? (~sample + 1'b1) : sample;
        mag_x = CMP_W'(mag);
        thr_x = CMP_W'(thr);
        evt.hi = (mag_x > thr_x);
        evt.lo = (mag_x < thr_x);
    end

endmodule

// File: rtl/event_combiner.sv
module event_combiner
    import mot_pkg::*;
#(
    parameter int N_EVT = EVT_W
) (
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] en,
    input  comb_mode_e       mode,
    output logic [N_EVT-1:0] evt_masked,
    output logic             cond
);
    always_comb begin
        evt_masked = evt & en;
        if (mode == COMB_AND)
            cond = (|en) && ((evt & en) == en);
        else
            cond = |evt_masked;
    end

endmodule

// File: rtl/duration_qual.sv
module duration_qual #(
    parameter int DUR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             cond,
    input  logic [DUR_W-1:0] dur,
    output logic             fire
);
    localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

    logic [DUR_W-1:0] run_cnt;

    assign fire = strobe && cond && (run_cnt >= dur);

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (strobe) begin
            if (!cond)
                run_cnt <= '0;
            else if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // R6
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !cond) |=> (run_cnt == '0));

    // R12
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(run_cnt));

endmodule

// File: rtl/source_reg.sv
module source_reg
    import mot_pkg::*;
#(
    parameter int N_EVT = EVT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             fire,
    input  logic [N_EVT-1:0] evt_masked,
    input  logic             latch_en,
    input  logic             rd,
    output logic [N_EVT:0]   src
);
    logic [N_EVT:0] fire_val;

    assign fire_val = {1'b1, evt_masked};

    always_ff @(posedge clk) begin
        if (rst)
            src <= '0;
        else if (latch_en) begin
            if (fire)
                src <= (rd ? '0 : src) | fire_val;
            else if (rd)
                src <= '0;
        end else if (strobe) begin
            src <= fire ? fire_val : '0;
        end
    end

    // R12
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !(latch_en && rd)) |=> $stable(src));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_en && rd && !fire) |=> (src == '0));

    // R7
    flag_has_evt_chk: assert property (@(posedge clk) disable iff (rst)
        src[N_EVT] |-> (|src[N_EVT-1:0]));

endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl
    import mot_pkg::*;
(
    input  logic     active,
    input  pin_cfg_t cfg,
    output logic     pad_o,
    output logic     pad_oe
);
    always_comb begin
        pad_o  = active ^ cfg.act_low;
        pad_oe = cfg.open_drain ? active : 1'b1;
    end

endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
    import mot_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int THR_W  = DEF_THR_W,
    parameter int DUR_W  = DEF_DUR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_x,
    input  logic signed [DATA_W-1:0] smp_y,
    input  logic signed [DATA_W-1:0] smp_z,
    input  logic [THR_W-1:0]         thr,
    input  logic [DUR_W-1:0]         dur,
    input  logic [EVT_W-1:0]         evt_en,
    input  logic                     comb_and,
    input  logic                     latch_en,
    input  logic                     src_rd,
    input  logic                     pin_act_low,
    input  logic                     pin_open_drain,
    output logic [SRC_W-1:0]         src_q,
    output logic                     irq_o,
    output logic                     irq_oe
);
    logic signed [DATA_W-1:0] axis_smp [NUM_AXES];
    axis_evt_t                axis_evt [NUM_AXES];
    logic [EVT_W-1:0]         evt_vec;
    logic [EVT_W-1:0]         evt_masked;
    logic                     cond;
    logic                     fire;
    comb_mode_e               mode;
    pin_cfg_t                 pcfg;

    assign axis_smp[0] = smp_x;
    assign axis_smp[1] = smp_y;
    assign axis_smp[2] = smp_z;
    assign mode        = comb_and ? COMB_AND : COMB_OR;
    assign pcfg        = '{act_low: pin_act_low, open_drain: pin_open_drain};

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        axis_cmp #(.DATA_W(DATA_W), .THR_W(THR_W)) u_cmp (
            .sample (axis_smp[a]),
            .thr    (thr),
            .evt    (axis_evt[a])
        );
        assign evt_vec[2*a]   = axis_evt[a].lo;
        assign evt_vec[2*a+1] = axis_evt[a].hi;
    end

    event_combiner #(.N_EVT(EVT_W)) u_comb (
        .evt        (evt_vec),
        .en         (evt_en),
        .mode       (mode),
        .evt_masked (evt_masked),
        .cond       (cond)
    );

    duration_qual #(.DUR_W(DUR_W)) u_dur (
        .clk    (clk),
        .rst    (rst),
        .strobe (smp_valid),
        .cond   (cond),
        .dur    (dur),
        .fire   (fire)
    );

    source_reg #(.N_EVT(EVT_W)) u_src (
        .clk        (clk),
        .rst        (rst),
        .strobe     (smp_valid),
        .fire       (fire),
        .evt_masked (evt_masked),
        .latch_en   (latch_en),
        .rd         (src_rd),
        .src        (src_q)
    );

    pad_ctrl u_pad (
        .active (src_q[SRC_W-1]),
        .cfg    (pcfg),
        .pad_o  (irq_o),
        .pad_oe (irq_oe)
    );

    // R11
    od_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_open_drain && !src_q[SRC_W-1]) |-> !irq_oe);

    // R10
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        irq_oe |-> (irq_o == (src_q[SRC_W-1] != pin_act_low)));

    // R8
    nolatch_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && smp_valid && fire) |=> src_q[SRC_W-1]);

endmodule

// File: tb/motion_irq_gen_test.sv
module motion_irq_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // {and(1), en(6), thr(7), x(8), y(8), z(8), exp_src(7)} = 45 bits
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 6'b000010, 7'd32,  8'd40,  8'd0,   8'd0,   7'h42}, // R3 X high
        {1'b0, 6'b000010, 7'd32,  8'hD8,  8'd0,   8'd0,   7'h42}, // R2 negative
        {1'b0, 6'b000010, 7'd32,  8'd32,  8'd0,   8'd0,   7'h00}, // R2 equal
        {1'b0, 6'b010101, 7'd32,  8'd5,   8'd100, 8'd100, 7'h41}, // R3 masked
        {1'b1, 6'b010101, 7'd32,  8'd5,   8'd3,   8'hFE,  7'h55}, // R4 all low
        {1'b1, 6'b010101, 7'd32,  8'd5,   8'd3,   8'd50,  7'h00}, // R4 one miss
        {1'b1, 6'b000000, 7'd32,  8'd100, 8'd0,   8'd0,   7'h00}, // R4 no enable
        {1'b0, 6'b101010, 7'd32,  8'h80,  8'd33,  8'd0,   7'h4A}, // R2 min neg
        {1'b0, 6'b111111, 7'd0,   8'd0,   8'd0,   8'd0,   7'h00}, // R2 thr 0
        {1'b0, 6'b111111, 7'd127, 8'd127, 8'h81,  8'd0,   7'h50}  // R2 thr max
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [6:0]        thr = 7'd32;
    logic [6:0]        dur = '0;
    logic [5:0]        evt_en = '0;
    logic              comb_and = 1'b0;
    logic              latch_en = 1'b0;
    logic              src_rd = 1'b0;
    logic              pin_act_low = 1'b0;
    logic              pin_open_drain = 1'b0;
    logic [6:0]        src_q;
    logic              irq_o, irq_oe;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    motion_irq_gen uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .thr(thr), .dur(dur), .evt_en(evt_en), .comb_and(comb_and),
        .latch_en(latch_en), .src_rd(src_rd),
        .pin_act_low(pin_act_low), .pin_open_drain(pin_open_drain),
        .src_q(src_q), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic chk_src(input string req, input logic [6:0] exp);
        total++;
        if (src_q !== exp) begin
            bad++;
            $display("FAIL %s src actual=%h expected=%h", req, src_q, exp);
        end
    endtask

    task automatic chk_pin(input string req, input logic eo, input logic eoe);
        total++;
        if (irq_o !== eo || irq_oe !== eoe) begin
            bad++;
            $display("FAIL %s pin actual=%b/%b expected=%b/%b", req, irq_o, irq_oe, eo, eoe);
        end
    endtask

    task automatic sample(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z,
                          input logic rd);
        @(negedge clk);
        smp_x = x; smp_y = y; smp_z = z;
        smp_valid = 1'b1; src_rd = rd;
        @(negedge clk);
        smp_valid = 1'b0; src_rd = 1'b0;
    endtask

    task automatic read_src();
        @(negedge clk);
        src_rd = 1'b1;
        @(negedge clk);
        src_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_src("R1", 7'h00);
        chk_pin("R1", 1'b0, 1'b1);

        // table walk, non-latched, dur 0
        for (int i = 0; i < NV; i++) begin
            comb_and = VEC[i][44];
            evt_en   = VEC[i][43:38];
            thr      = VEC[i][37:31];
            sample(VEC[i][30:23], VEC[i][22:15], VEC[i][14:7], 1'b0);
            chk_src($sformatf("R7 vec%0d", i), VEC[i][6:0]);
            chk_pin("R10", VEC[i][6], 1'b1);
        end

        // R5 duration qualification
        comb_and = 1'b0; evt_en = 6'b000010; thr = 7'd32; dur = 7'd2;
        sample(8'd0, 8'd0, 8'd0, 1'b0);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R5 run1", 7'h00);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R5 run2", 7'h00);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R5 run3", 7'h42);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R5 run4", 7'h42);

        // R6 restart of count, R8 clear on quiet sample
        sample(8'd0, 8'd0, 8'd0, 1'b0);  chk_src("R8 quiet", 7'h00);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R6 r1", 7'h00);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R6 r2", 7'h00);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R6 r3", 7'h42);

        // R12 inputs without strobe ignored
        @(negedge clk);
        smp_x = 8'd0;
        repeat (4) @(negedge clk);
        chk_src("R12 idle", 7'h42);
        // R8 read has no effect when not latched
        read_src();
        chk_src("R8 read", 7'h42);

        // R9 latched mode
        dur = 7'd0; latch_en = 1'b1; evt_en = 6'b001010;
        sample(8'd0, 8'd0, 8'd0, 1'b0);  chk_src("R9 hold", 7'h42);
        read_src();                      chk_src("R9 clear", 7'h00);
        sample(8'd40, 8'd0, 8'd0, 1'b0); chk_src("R9 fire", 7'h42);
        sample(8'd0, 8'd40, 8'd0, 1'b0); chk_src("R9 or-in", 7'h4A);
        sample(8'd0, 8'd40, 8'd0, 1'b1); chk_src("R9 rd+fire", 7'h48);

        // R10 polarity, R11 drive
        pin_act_low = 1'b1;
        #1 chk_pin("R10 low active", 1'b0, 1'b1);
        pin_open_drain = 1'b1;
        #1 chk_pin("R11 od active", 1'b0, 1'b1);
        read_src();
        chk_pin("R11 od release", 1'b1, 1'b0);
        pin_act_low = 1'b0;
        #1 chk_pin("R11 od release hi", 1'b0, 1'b0);
        pin_open_drain = 1'b0;
        #1 chk_pin("R11 push-pull idle", 1'b0, 1'b1);

        // R1 reset mid-activity
        sample(8'd40, 8'd0, 8'd0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk_src("R1 re-reset", 7'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule